// File: doc/BRIEF.md
# Power-on Reset Timeout Sequencer

This block keeps a processor core in reset after power is applied, and again when the core leaves a low-power state, until its clock source can be trusted. After the power-on pulse goes away it runs a chain of timeouts. The first is a power-up delay counted on an internal RC clock. The second is a start-up count of cycles of an external crystal or resonator. The third, used only with the phase-locked multiplier, is a lock wait. Which of these stages run depends on the selected oscillator mode, on a configuration bit, and on whether the wake-up is a cold start or a return from a power-managed state.

An active-low external reset pin is merged into the core reset. The timeouts always run from the power-on pulse and never from the pin. If the pin is held low past the end of every timeout, the core starts as soon as the pin is released, which lets several devices start in lock-step. The pin and the oscillator-side done flag are brought into the internal clock domain through two-flop synchronizers. A stage indicator shows the position in the sequence.

Top module: `por_tmo_seq`

## Requirements
- R1: While `por_i` is high, `core_rst_o` is 1, `stage_o` is 0 (idle) and `tmo_done_o` is 0.
- R2: With `pwrt_off_i` = 0, the power-up stage (`stage_o` = 1) lasts exactly 2^PWRT_W internal clock cycles. With `pwrt_off_i` = 1, stage 1 never appears.
- R3: After a power-on reset the stages only move forward: idle (0), power-up (1), oscillator start-up (2), lock wait (3), run (4). The first internal clock edge after `por_i` falls leaves idle.
- R4: The start-up stage waits OST_CYCLES cycles of `clk_osc_i`, counted only after the power-up stage has ended. Two synchronizer flops are added in each direction.
- R5: Stage 2 appears only for `osc_mode_i` codes 0, 1, 2 and 3 (three crystal or resonator modes and the multiplied high-speed mode). Codes 4 (external clock), 5 (RC) and 6 (internal) skip it.
- R6: Stage 3 appears only for code 3. It follows stage 2 and lasts exactly PLL_TICKS internal clock cycles.
- R7: In RC mode (code 5) with `pwrt_off_i` = 1, `core_rst_o` falls at the first internal clock edge after `por_i` falls.
- R8: A one-cycle `pm_exit_i` pulse in run mode with mode code 0 to 3 goes straight to stage 2 and then, for code 3 only, to stage 3. It never enters stage 1. With codes 4 to 6 the pulse has no effect: the stage stays at 4 and `core_rst_o` stays 0.
- R9: `core_rst_o` is 1 while the synchronized `mclr_n_i` is 0. This does not stop or restart the timeouts. When the pin rises after the sequence has reached run, `core_rst_o` falls on the second internal clock edge after the rise.
- R10: Raising `por_i` in any stage returns the block to idle and restarts the whole sequence after `por_i` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_int_i | input | 1 | Internal RC clock that runs the sequencer |
| clk_osc_i | input | 1 | External oscillator clock, counted during start-up |
| por_i | input | 1 | Power-on pulse, active high, asynchronous |
| pm_exit_i | input | 1 | One-cycle request to leave a power-managed state (internal clock domain) |
| osc_mode_i | input | 3 | Oscillator mode: 0 LP, 1 XT, 2 HS, 3 HS with PLL, 4 EC, 5 RC, 6 internal |
| pwrt_off_i | input | 1 | 1 skips the power-up delay |
| mclr_n_i | input | 1 | External reset pin, active low, asynchronous |
| core_rst_o | output | 1 | Reset to the core, active high |
| stage_o | output | 3 | Current stage: 0 idle, 1 power-up, 2 start-up, 3 lock, 4 run |
| tmo_done_o | output | 1 | High once every timeout has expired |

## Verification
A table walks each oscillator mode with the power-up delay both on and off, and measures the number of cycles from the end of the power-on pulse to release. It also records which stages appear and checks that they only move forward, so the run shows whether the power-up, start-up and lock stages are each correctly present or absent. Directed cases cover wake-up from a power-managed state in crystal, multiplied and non-crystal modes. They also cover a reset pin held low past every timeout, a pin pulse during run, and a new power-on pulse in the middle of the power-up stage. Between them these cases separate a pin-driven sequence from a pulse-driven one, and a restart from a resume.

// File: rtl/por_tmo_pkg.sv
package por_tmo_pkg;
   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_PWRT = 3'd1,
      ST_OST  = 3'd2,
      ST_PLL  = 3'd3,
      ST_RUN  = 3'd4
   } stage_e;

   localparam logic [2:0] MODE_LP    = 3'd0;
   localparam logic [2:0] MODE_XT    = 3'd1;
   localparam logic [2:0] MODE_HS    = 3'd2;
   localparam logic [2:0] MODE_HSPLL = 3'd3;
   localparam logic [2:0] MODE_EC    = 3'd4;
   localparam logic [2:0] MODE_RC    = 3'd5;
   localparam logic [2:0] MODE_INT   = 3'd6;

   function automatic logic mode_xtal(input logic [2:0] m);
      return (m == MODE_LP) || (m == MODE_XT) || (m == MODE_HS) || (m == MODE_HSPLL);
   endfunction

   function automatic logic mode_pll(input logic [2:0] m);
      return m == MODE_HSPLL;
   endfunction
endpackage

// File: rtl/por_tmo_sync.sv
module por_tmo_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic arst_i,
   input  logic d_i,
   output logic q_o
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("por_tmo_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_flop
         always_ff @(posedge clk_i or posedge arst_i) begin
            if (arst_i)      chain_q[i] <= 1'b0;
            else if (i == 0) chain_q[i] <= d_i;
            else             chain_q[i] <= chain_q[(i > 0) ? i - 1 : 0];
         end
      end
   endgenerate

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/por_tmo_ost.sv
module por_tmo_ost #(
   parameter int OST_CYCLES = 1024,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk_osc_i,
   input  logic por_i,
   input  logic start_i,
   output logic done_o
);
   localparam int CW = $clog2(OST_CYCLES);

   logic          req_s;
   logic [CW-1:0] cnt_q;
   logic          done_q;

   por_tmo_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk_i (clk_osc_i),
      .arst_i(por_i),
      .d_i   (start_i),
      .q_o   (req_s)
   );

   always_ff @(posedge clk_osc_i or posedge por_i) begin
      if (por_i) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!req_s) begin
         cnt_q  <= '0;
         done_q <= 1'b0;
      end else if (!done_q) begin
         if (cnt_q == CW'(OST_CYCLES - 1)) done_q <= 1'b1;
         else                              cnt_q  <= cnt_q + 1'b1;
      end
   end

   assign done_o = done_q;

   // R4
   ost_done_needs_req_chk: assert property (@(posedge clk_osc_i) disable iff (por_i)
      $rose(done_q) |-> req_s);
   // R4
   ost_done_holds_chk: assert property (@(posedge clk_osc_i) disable iff (por_i)
      (done_q && req_s) |=> done_q);
endmodule

// File: rtl/por_tmo_fsm.sv
module por_tmo_fsm
   import por_tmo_pkg::*;
#(
   parameter int PWRT_TICKS = 2048,
   parameter int PLL_TICKS  = 62
) (
   input  logic       clk_i,
   input  logic       por_i,
   input  logic       pm_exit_i,
   input  logic [2:0] mode_i,
   input  logic       pwrt_off_i,
   input  logic       ost_done_i,
   output logic       ost_start_o,
   output stage_e     stage_o
);
   localparam int MAXT = (PWRT_TICKS > PLL_TICKS) ? PWRT_TICKS : PLL_TICKS;
   localparam int CW   = $clog2(MAXT + 1);

   stage_e        stage_q, stage_d;
   logic [CW-1:0] cnt_q, load_val;
   logic          load;
   logic          armed_q;
   logic          xtal, pll;

   assign xtal = mode_xtal(mode_i);
   assign pll  = mode_pll(mode_i);

   always_comb begin
      stage_d  = stage_q;
      load     = 1'b0;
      load_val = '0;
      unique case (stage_q)
         ST_IDLE: begin
            if (!pwrt_off_i) begin
               stage_d  = ST_PWRT;
               load     = 1'b1;
               load_val = CW'(PWRT_TICKS - 1);
            end else if (xtal) stage_d = ST_OST;
            else               stage_d = ST_RUN;
         end
         ST_PWRT: if (cnt_q == '0) stage_d = xtal ? ST_OST : ST_RUN;
         ST_OST: begin
            if (armed_q && ost_done_i) begin
               if (pll) begin
                  stage_d  = ST_PLL;
                  load     = 1'b1;
                  load_val = CW'(PLL_TICKS - 1);
               end else stage_d = ST_RUN;
            end
         end
         ST_PLL: if (cnt_q == '0) stage_d = ST_RUN;
         ST_RUN: if (pm_exit_i && xtal) stage_d = ST_OST;
         default: stage_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or posedge por_i) begin
      if (por_i) begin
         stage_q <= ST_IDLE;
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else begin
         stage_q <= stage_d;
         if (load)              cnt_q <= load_val;
         else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
         armed_q <= (stage_q == ST_OST) && (armed_q || !ost_done_i);
      end
   end

   assign ost_start_o = (stage_q == ST_OST);
   assign stage_o     = stage_q;

   // R3
   idle_leaves_chk: assert property (@(posedge clk_i) disable iff (por_i)
      stage_q == ST_IDLE |=> stage_q != ST_IDLE);
   // R2
   pwrt_enabled_chk: assert property (@(posedge clk_i) disable iff (por_i)
      stage_q == ST_PWRT |-> !pwrt_off_i);
   // R5
   ost_xtal_only_chk: assert property (@(posedge clk_i) disable iff (por_i)
      stage_q == ST_OST |-> mode_xtal(mode_i));
   // R6
   pll_mode_only_chk: assert property (@(posedge clk_i) disable iff (por_i)
      stage_q == ST_PLL |-> mode_pll(mode_i));
   // R6
   pll_after_ost_chk: assert property (@(posedge clk_i) disable iff (por_i)
      (stage_q == ST_PLL && $past(stage_q) != ST_PLL) |-> $past(stage_q) == ST_OST);
   // R8
   run_exit_ost_chk: assert property (@(posedge clk_i) disable iff (por_i)
      stage_q == ST_RUN |=> (stage_q == ST_RUN || stage_q == ST_OST));
endmodule

// File: rtl/por_tmo_seq.sv
module por_tmo_seq
   import por_tmo_pkg::*;
#(
   parameter int PWRT_W      = 11,
   parameter int OST_CYCLES  = 1024,
   parameter int INTCLK_HZ   = 31250,
   parameter int PLL_TICKS   = INTCLK_HZ / 500,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk_int_i,
   input  logic       clk_osc_i,
   input  logic       por_i,
   input  logic       pm_exit_i,
   input  logic [2:0] osc_mode_i,
   input  logic       pwrt_off_i,
   input  logic       mclr_n_i,
   output logic       core_rst_o,
   output logic [2:0] stage_o,
   output logic       tmo_done_o
);
   localparam int PWRT_TICKS = 1 << PWRT_W;

   generate
      if (PWRT_W < 2 || PWRT_W > 20) begin : g_bad_pwrt
         $error("por_tmo_seq: PWRT_W out of range");
      end
      if (OST_CYCLES < 2) begin : g_bad_ost
         $error("por_tmo_seq: OST_CYCLES must be at least 2");
      end
      if (PLL_TICKS < 1) begin : g_bad_pll
         $error("por_tmo_seq: PLL_TICKS must be at least 1");
      end
   endgenerate

   logic   mclr_s, ost_start, ost_done_osc, ost_done_s;
   stage_e stage;

   por_tmo_sync #(.STAGES(SYNC_STAGES)) u_mclr_sync (
      .clk_i (clk_int_i),
      .arst_i(1'b0),
      .d_i   (mclr_n_i),
      .q_o   (mclr_s)
   );

   por_tmo_sync #(.STAGES(SYNC_STAGES)) u_done_sync (
      .clk_i (clk_int_i),
      .arst_i(por_i),
      .d_i   (ost_done_osc),
      .q_o   (ost_done_s)
   );

   por_tmo_ost #(.OST_CYCLES(OST_CYCLES), .SYNC_STAGES(SYNC_STAGES)) u_ost (
      .clk_osc_i(clk_osc_i),
      .por_i    (por_i),
      .start_i  (ost_start),
      .done_o   (ost_done_osc)
   );

   por_tmo_fsm #(.PWRT_TICKS(PWRT_TICKS), .PLL_TICKS(PLL_TICKS)) u_fsm (
      .clk_i      (clk_int_i),
      .por_i      (por_i),
      .pm_exit_i  (pm_exit_i),
      .mode_i     (osc_mode_i),
      .pwrt_off_i (pwrt_off_i),
      .ost_done_i (ost_done_s),
      .ost_start_o(ost_start),
      .stage_o    (stage)
   );

   assign tmo_done_o = (stage == ST_RUN);
   assign core_rst_o = !tmo_done_o || !mclr_s;
   assign stage_o    = stage;

   // R9
   pin_low_holds_chk: assert property (@(posedge clk_int_i) disable iff (por_i)
      (!$past(mclr_n_i) && !mclr_n_i) |=> core_rst_o);
   // R1
   por_idle_chk: assert property (@(posedge clk_int_i)
      por_i |-> (core_rst_o && !tmo_done_o));
endmodule

// File: tb/por_tmo_seq_test.sv
module por_tmo_seq_test;
   logic       clk = 1'b0, osc = 1'b0;
   logic       por = 1'b1, pm = 1'b0, dis = 1'b0, mclr = 1'b1;
   logic [2:0] mode = 3'd4;
   logic       core_rst, done;
   logic [2:0] stage;
   int         n_chk = 0, n_bad = 0, cyc = 0;

   always #10 clk = ~clk;
   initial begin
      #3;
      forever #5 osc = ~osc;
   end

   por_tmo_seq #(.PWRT_W(4), .OST_CYCLES(16), .PLL_TICKS(5)) uut (
      .clk_int_i(clk), .clk_osc_i(osc), .por_i(por), .pm_exit_i(pm),
      .osc_mode_i(mode), .pwrt_off_i(dis), .mclr_n_i(mclr),
      .core_rst_o(core_rst), .stage_o(stage), .tmo_done_o(done)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic finish_run;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
         finish_run();
      end
   end

   // counts edges after por/pm event until core_rst falls; tracks stages seen
   task automatic walk(output int n, output bit s1, output bit s2, output bit s3, output bit mono);
      int prev;
      n = 0; s1 = 0; s2 = 0; s3 = 0; mono = 1; prev = 0;
      forever begin
         @(posedge clk); #1;
         n++;
         if (int'(stage) < prev) mono = 0;
         prev = int'(stage);
         if (stage == 3'd1) s1 = 1;
         if (stage == 3'd2) s2 = 1;
         if (stage == 3'd3) s3 = 1;
         if (!core_rst || n > 400) break;
      end
   endtask

   task automatic start_por(input logic [2:0] m, input logic d);
      @(negedge clk);
      por = 1'b1; mode = m; dis = d;
      repeat (4) @(negedge clk);
      chk(core_rst && stage == 3'd0 && !done, "R1 reset state", {core_rst, stage, done}, 5'b10000);
      por = 1'b0;
   endtask

   // {mode, pwrt_off, lo, hi}
   localparam logic [19:0] VEC [10] = '{
      {3'd4, 1'b0, 8'd17, 8'd17},
      {3'd4, 1'b1, 8'd1,  8'd1 },
      {3'd5, 1'b0, 8'd17, 8'd17},
      {3'd5, 1'b1, 8'd1,  8'd1 },
      {3'd6, 1'b1, 8'd1,  8'd1 },
      {3'd2, 1'b0, 8'd25, 8'd33},
      {3'd1, 1'b1, 8'd9,  8'd17},
      {3'd0, 1'b0, 8'd25, 8'd33},
      {3'd3, 1'b0, 8'd30, 8'd38},
      {3'd3, 1'b1, 8'd14, 8'd22}
   };

   initial begin
      int n;
      bit s1, s2, s3, mono;
      repeat (3) @(negedge clk);
      chk(core_rst && stage == 3'd0 && !done, "R1 initial reset", stage, 0);

      for (int i = 0; i < 10; i++) begin
         logic [2:0] m;
         logic       d;
         int         lo, hi;
         m = VEC[i][19:17]; d = VEC[i][16]; lo = int'(VEC[i][15:8]); hi = int'(VEC[i][7:0]);
         start_por(m, d);
         walk(n, s1, s2, s3, mono);
         chk(n >= lo && n <= hi, "R4/R7 release cycle", n, lo);
         chk(s1 == !d, "R2 power-up stage presence", s1, !d);
         chk(s2 == (m <= 3'd3), "R5 start-up stage presence", s2, m <= 3'd3);
         chk(s3 == (m == 3'd3), "R6 lock stage presence", s3, m == 3'd3);
         chk(mono, "R3 stage order", mono, 1);
         chk(done && stage == 3'd4, "R3 run reached", stage, 4);
      end

      // R8: wake-up in HS mode
      start_por(3'd2, 1'b1); walk(n, s1, s2, s3, mono);
      repeat (3) @(negedge clk);
      pm = 1'b1; @(negedge clk); pm = 1'b0;
      walk(n, s1, s2, s3, mono);
      chk(n >= 8 && n <= 16, "R8 HS wake release", n, 12);
      chk(!s1 && s2 && !s3, "R8 HS wake stages", {s1, s2, s3}, 3'b010);

      // R8: wake-up in HSPLL mode with power-up delay enabled
      start_por(3'd3, 1'b0); walk(n, s1, s2, s3, mono);
      repeat (3) @(negedge clk);
      pm = 1'b1; @(negedge clk); pm = 1'b0;
      walk(n, s1, s2, s3, mono);
      chk(n >= 13 && n <= 21, "R8 HSPLL wake release", n, 17);
      chk(!s1 && s2 && s3, "R8 HSPLL wake stages", {s1, s2, s3}, 3'b011);

      // R8: wake-up in EC mode has no effect
      start_por(3'd4, 1'b1); walk(n, s1, s2, s3, mono);
      @(negedge clk); pm = 1'b1; @(negedge clk); pm = 1'b0;
      s1 = 0;
      for (int k = 0; k < 10; k++) begin
         @(posedge clk); #1;
         if (core_rst || stage != 3'd4) s1 = 1;
      end
      chk(!s1, "R8 EC wake ignored", stage, 4);

      // R9: pin held low past all timeouts
      @(negedge clk); mclr = 1'b0;
      start_por(3'd4, 1'b0);
      repeat (40) @(negedge clk);
      chk(core_rst && stage == 3'd4 && done, "R9 pin holds reset, timeouts expire", {core_rst, stage}, 4'b1100);
      mclr = 1'b1;
      @(posedge clk); #1;
      chk(core_rst, "R9 one edge after pin rise", core_rst, 1);
      @(posedge clk); #1;
      chk(!core_rst, "R9 release on second edge", core_rst, 0);

      // R9: pin pulse during run does not restart timeouts
      @(negedge clk); mclr = 1'b0;
      repeat (4) @(negedge clk);
      chk(core_rst && stage == 3'd4, "R9 pin pulse in run", {core_rst, stage}, 4'b1100);
      mclr = 1'b1;
      repeat (3) @(negedge clk);
      chk(!core_rst && stage == 3'd4, "R9 pin pulse recovery", {core_rst, stage}, 4'b0100);

      // R10: new power-on pulse in the middle of the power-up stage
      start_por(3'd4, 1'b0);
      repeat (6) @(negedge clk);
      chk(stage == 3'd1, "R10 in power-up stage", stage, 1);
      por = 1'b1; #1;
      chk(stage == 3'd0 && core_rst, "R10 back to idle", stage, 0);
      @(negedge clk); por = 1'b0;
      walk(n, s1, s2, s3, mono);
      chk(n == 17, "R10 full restart length", n, 17);

      finish_run();
   end
endmodule